// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block times the multiplexed external memory bus of a small 8-bit controller core. The core asks for one access at a time: an instruction fetch at a program counter address, or a data read or data write at a data pointer address. The block turns each external access into one machine cycle of twelve clock phases. It places the high address byte on the upper port for the whole cycle. The low address byte goes on the shared low port, where an address latch enable pulse tells external latches to capture it. The low port then turns around for the data phase, while one active-low strobe (program store, read or write) frames the transfer.

A fetch below the on-chip code limit, made while the on-chip code enable input is high, never reaches the bus. It still takes one full machine cycle, with the bus pins quiet, and returns the byte presented on the on-chip ROM data input. Data accesses always go to the bus. Every access, on-chip or external, finishes with a one-clock done pulse, and the returned byte is valid from that pulse on.

States: `ST_IDLE` (no access), `ST_ADDR` (latch enable high, address out), `ST_HOLD` (latch enable low, address held), `ST_ACCESS` (low port turned around, strobe window), `ST_RECOVER` (strobes high, done), `ST_ONCHIP` (on-chip fetch, bus quiet). Transitions: `ST_IDLE` goes to `ST_ADDR` or `ST_ONCHIP` when a request is accepted. `ST_ADDR` goes to `ST_HOLD` after the last latch-enable phase. `ST_HOLD` goes to `ST_ACCESS` after one phase. `ST_ACCESS` goes to `ST_RECOVER` after the last strobe phase. `ST_RECOVER`, and `ST_ONCHIP` in its last phase, go to `ST_ADDR` or `ST_ONCHIP` if a new request arrives in that clock, and to `ST_IDLE` otherwise.

Top module: `mbus_sequencer`

## Requirements
- R1: While reset is held and right after it, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, `p0_oe` is 0, `rom_en` is 0 and `done` is 0.
- R2: `acc_kind` codes are 0 fetch, 1 data read, 2 data write. Code 3 is not used. A request is taken on a clock edge where `acc_start` is high and the block is idle or in the last phase of a cycle. Phases 0 to 11 of that access then follow, one per clock, starting with the clock after that edge.
- R3: On an external access, `ale` is high in phases 0 and 1 and low in phases 2 to 11.
- R4: On an external access, the low port drives address bits 7:0 in phases 0 to 2, so the address is held one phase past the fall of `ale`.
- R5: On an external access, `p2_out` carries address bits 15:8 in all twelve phases. The address comes from `pc` for a fetch and from `dptr` for a data access.
- R6: On an external fetch, `psen_n` is low in phases 3 to 5 only. The byte on `p0_in` at the end of phase 5 is returned on `rdata`.
- R7: On a data read, `rd_n` is low in phases 5 to 10 only. The byte on `p0_in` at the end of phase 10 is returned on `rdata`. `ale` rises no earlier than one phase after `rd_n` rises.
- R8: On a data write, `wr_n` is low in phases 5 to 10 only. The write byte is driven in phases 4 to 11, so it is valid before the strobe falls and held one phase after it rises.
- R9: The low port is not driven in phase 3 of any access, nor in phases 3 to 11 of a fetch or read. It is never driven while `psen_n` or `rd_n` is low, and at most one strobe is low at a time.
- R10: A fetch with `onchip_code_en` high and `pc` below 4096 is served on chip. `rom_en` is high for its twelve phases, `ale` stays low, every strobe stays high, the low port is not driven, and `rdata` returns `rom_rdata`. A fetch with `pc` at 4096 or above, or any fetch with `onchip_code_en` low, goes to the bus.
- R11: `done` is high for exactly one clock, in phase 11. A request given in that clock starts the next access in the following clock, with no idle phase between.
- R12: Data reads and writes always use the bus, whatever the value of `onchip_code_en` and whatever the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; one phase per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_start | input | 1 | Request strobe for a new access |
| acc_kind | input | 2 | 0 fetch, 1 data read, 2 data write |
| pc | input | 16 | Program counter address for fetches |
| dptr | input | 16 | Data pointer address for data accesses |
| wdata | input | 8 | Byte to write |
| onchip_code_en | input | 1 | High: low code addresses are served on chip |
| rom_rdata | input | 8 | Byte from the on-chip code store |
| p0_in | input | 8 | Low port input from the external bus |
| p0_out | output | 8 | Low port output value (address or write data) |
| p0_oe | output | 1 | Low port output enable |
| p2_out | output | 8 | Upper port: address bits 15:8 |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| rom_en | output | 1 | High during an on-chip fetch cycle |
| rdata | output | 8 | Returned instruction or data byte |
| done | output | 1 | One-clock pulse at the end of an access |

## Verification
The assertions take for granted that `acc_kind` never carries code 3 when `acc_start` is high, and that a request stays stable for the clock in which it is accepted. They do not check behaviour when `acc_start` is raised mid-cycle, because the block ignores such a request. The stimulus raises `acc_start` only while the block is idle or in the done clock. It uses only the three defined kinds, and it serves `p0_in` from a memory model that drives a known byte only while `psen_n` or `rd_n` is low, so a wrongly timed sample shows up as a bad returned byte.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int BUS_ADDR_W = 16;
    localparam int BUS_DATA_W = 8;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_NONE  = 2'd3
    } acc_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ADDR    = 3'd1,
        ST_HOLD    = 3'd2,
        ST_ACCESS  = 3'd3,
        ST_RECOVER = 3'd4,
        ST_ONCHIP  = 3'd5
    } seq_state_t;

endpackage

// File: rtl/mbus_phase_timer.sv
module mbus_phase_timer #(
    parameter int CYC_LEN = 12,
    localparam int PH_W = $clog2(CYC_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            run,
    output logic [PH_W-1:0] ph,
    output logic            last
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_LEN - 1);

    assign last = (ph == PH_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph <= '0;
        end else if (restart) begin
            ph <= '0;
        end else if (run) begin
            ph <= last ? '0 : ph + 1'b1;
        end
    end

    // R2: the phase never leaves the machine cycle
    p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ph <= PH_LAST);

endmodule

// File: rtl/mbus_src_select.sv
module mbus_src_select
    import mbus_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int ONCHIP_LIMIT = 4096
) (
    input  acc_kind_t          kind,
    input  logic [ADDR_W-1:0]  pc,
    input  logic [ADDR_W-1:0]  dptr,
    input  logic               onchip_code_en,
    output logic               use_onchip,
    output logic [ADDR_W-1:0]  sel_addr
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(ONCHIP_LIMIT);

    logic below_limit;

    always_comb begin
        below_limit = ({1'b0, pc} < LIMIT);
        use_onchip  = (kind == ACC_FETCH) && onchip_code_en && below_limit;
        sel_addr    = (kind == ACC_FETCH) ? pc : dptr;
    end

endmodule

// File: rtl/mbus_pin_drive.sv
module mbus_pin_drive
    import mbus_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int PH_W     = 4,
    parameter int PSEN_BEG = 3,
    parameter int PSEN_END = 5,
    parameter int STB_BEG  = 5,
    parameter int STB_END  = 10,
    parameter int WD_BEG   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  seq_state_t         state,
    input  acc_kind_t          kind,
    input  logic [PH_W-1:0]    ph,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic               ale,
    output logic               psen_n,
    output logic               rd_n,
    output logic               wr_n,
    output logic [DATA_W-1:0]  p0_out,
    output logic               p0_oe,
    output logic [ADDR_W-DATA_W-1:0] p2_out,
    output logic               rom_en
);

    localparam logic [PH_W-1:0] PS_B = PH_W'(PSEN_BEG);
    localparam logic [PH_W-1:0] PS_E = PH_W'(PSEN_END);
    localparam logic [PH_W-1:0] ST_B = PH_W'(STB_BEG);
    localparam logic [PH_W-1:0] ST_E = PH_W'(STB_END);
    localparam logic [PH_W-1:0] WD_B = PH_W'(WD_BEG);

    logic in_psen_win;
    logic in_stb_win;
    logic addr_phase;
    logic wr_drive;
    logic on_bus;

    always_comb begin
        in_psen_win = (ph >= PS_B) && (ph <= PS_E);
        in_stb_win  = (ph >= ST_B) && (ph <= ST_E);
        addr_phase  = (state == ST_ADDR) || (state == ST_HOLD);
        on_bus      = (state != ST_IDLE) && (state != ST_ONCHIP);
        wr_drive    = (kind == ACC_WRITE) &&
                      (((state == ST_ACCESS) && (ph >= WD_B)) || (state == ST_RECOVER));

        ale    = (state == ST_ADDR);
        psen_n = !((state == ST_ACCESS) && (kind == ACC_FETCH) && in_psen_win);
        rd_n   = !((state == ST_ACCESS) && (kind == ACC_READ)  && in_stb_win);
        wr_n   = !((state == ST_ACCESS) && (kind == ACC_WRITE) && in_stb_win);
        p0_oe  = addr_phase || wr_drive;
        if (addr_phase) begin
            p0_out = addr[DATA_W-1:0];
        end else if (wr_drive) begin
            p0_out = wdata;
        end else begin
            p0_out = '0;
        end
        p2_out = on_bus ? addr[ADDR_W-1:DATA_W] : '0;
        rom_en = (state == ST_ONCHIP);
    end

    // R9: the low port is released whenever a device may drive it
    p_no_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!psen_n || !rd_n) |-> !p0_oe);

    // R9: strobes are mutually exclusive
    p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!psen_n, !rd_n, !wr_n}) <= 1);

    // R3: latch enable never overlaps a strobe
    p_ale_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (psen_n && rd_n && wr_n));

endmodule

// File: rtl/mbus_sequencer.sv
module mbus_sequencer
    import mbus_pkg::*;
#(
    parameter int ADDR_W       = BUS_ADDR_W,
    parameter int DATA_W       = BUS_DATA_W,
    parameter int ONCHIP_LIMIT = 4096,
    parameter int ALE_LEN      = 2,
    parameter int PSEN_LEN     = 3,
    parameter int STB_LEN      = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acc_start,
    input  logic [1:0]               acc_kind,
    input  logic [ADDR_W-1:0]        pc,
    input  logic [ADDR_W-1:0]        dptr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     onchip_code_en,
    input  logic [DATA_W-1:0]        rom_rdata,
    input  logic [DATA_W-1:0]        p0_in,
    output logic [DATA_W-1:0]        p0_out,
    output logic                     p0_oe,
    output logic [ADDR_W-DATA_W-1:0] p2_out,
    output logic                     ale,
    output logic                     psen_n,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     rom_en,
    output logic [DATA_W-1:0]        rdata,
    output logic                     done
);

    localparam int ALE_END  = ALE_LEN - 1;
    localparam int PSEN_BEG = ALE_LEN + 1;
    localparam int PSEN_END = PSEN_BEG + PSEN_LEN - 1;
    localparam int STB_BEG  = ALE_LEN + 3;
    localparam int STB_END  = STB_BEG + STB_LEN - 1;
    localparam int WD_BEG   = STB_BEG - 1;
    localparam int CYC_LEN  = STB_END + 2;
    localparam int PH_W     = $clog2(CYC_LEN);

    localparam logic [PH_W-1:0] PH_ALE_END  = PH_W'(ALE_END);
    localparam logic [PH_W-1:0] PH_PSEN_END = PH_W'(PSEN_END);
    localparam logic [PH_W-1:0] PH_STB_END  = PH_W'(STB_END);

    seq_state_t          state_q, state_d;
    acc_kind_t           kind_in, kind_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [PH_W-1:0]     ph;
    logic                ph_last;
    logic                use_onchip;
    logic [ADDR_W-1:0]   sel_addr;
    logic                accept;
    seq_state_t          launch_state;

    assign kind_in = acc_kind_t'(acc_kind);

    mbus_src_select #(
        .ADDR_W       (ADDR_W),
        .ONCHIP_LIMIT (ONCHIP_LIMIT)
    ) u_src (
        .kind           (kind_in),
        .pc             (pc),
        .dptr           (dptr),
        .onchip_code_en (onchip_code_en),
        .use_onchip     (use_onchip),
        .sel_addr       (sel_addr)
    );

    mbus_phase_timer #(
        .CYC_LEN (CYC_LEN)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .run     (state_q != ST_IDLE),
        .ph      (ph),
        .last    (ph_last)
    );

    assign accept = acc_start &&
                    ((state_q == ST_IDLE) ||
                     (((state_q == ST_RECOVER) || (state_q == ST_ONCHIP)) && ph_last));
    assign launch_state = use_onchip ? ST_ONCHIP : ST_ADDR;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = accept ? launch_state : ST_IDLE;
            ST_ADDR:    state_d = (ph == PH_ALE_END) ? ST_HOLD : ST_ADDR;
            ST_HOLD:    state_d = ST_ACCESS;
            ST_ACCESS:  state_d = (ph == PH_STB_END) ? ST_RECOVER : ST_ACCESS;
            ST_RECOVER: state_d = accept ? launch_state : ST_IDLE;
            ST_ONCHIP:  state_d = ph_last ? (accept ? launch_state : ST_IDLE) : ST_ONCHIP;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= ACC_FETCH;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                kind_q  <= kind_in;
                addr_q  <= sel_addr;
                wdata_q <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            unique case (state_q)
                ST_ACCESS: begin
                    if (kind_q == ACC_FETCH && ph == PH_PSEN_END) rdata <= p0_in;
                    if (kind_q == ACC_READ  && ph == PH_STB_END)  rdata <= p0_in;
                end
                ST_ONCHIP: begin
                    if (ph == PH_PSEN_END) rdata <= rom_rdata;
                end
                default: ;
            endcase
        end
    end

    assign done = (state_q == ST_RECOVER) || ((state_q == ST_ONCHIP) && ph_last);

    mbus_pin_drive #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .PH_W     (PH_W),
        .PSEN_BEG (PSEN_BEG),
        .PSEN_END (PSEN_END),
        .STB_BEG  (STB_BEG),
        .STB_END  (STB_END),
        .WD_BEG   (WD_BEG)
    ) u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .state  (state_q),
        .kind   (kind_q),
        .ph     (ph),
        .addr   (addr_q),
        .wdata  (wdata_q),
        .ale    (ale),
        .psen_n (psen_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .p0_out (p0_out),
        .p0_oe  (p0_oe),
        .p2_out (p2_out),
        .rom_en (rom_en)
    );

    // R2: only defined access kinds are requested
    p_kind_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_start |-> (acc_kind != 2'd3));

    // R11: done is a single-clock pulse
    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: address still driven in the phase after latch enable falls
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> p0_oe);

    // R8: write data held in the phase after the write strobe rises
    p_wdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> p0_oe);

    // R7: latch enable rises only after both data strobes were already high
    p_ale_after_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |-> ($past(rd_n) && $past(wr_n)));

    // R10: an on-chip fetch leaves the bus quiet
    p_onchip_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rom_en |-> (!ale && psen_n && rd_n && wr_n && !p0_oe));

endmodule

// File: tb/mbus_sequencer_tb.sv
`timescale 1ns/1ps
module mbus_sequencer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_start = 1'b0;
    logic [1:0]  acc_kind = 2'd0;
    logic [15:0] pc = '0;
    logic [15:0] dptr = '0;
    logic [7:0]  wdata = '0;
    logic        onchip_code_en = 1'b0;
    logic [7:0]  rom_rdata = '0;
    logic [7:0]  p0_in;
    logic [7:0]  p0_out;
    logic        p0_oe;
    logic [7:0]  p2_out;
    logic        ale, psen_n, rd_n, wr_n, rom_en, done;
    logic [7:0]  rdata;

    int checks = 0;
    int failures = 0;

    typedef struct {
        int          kind;
        bit          ext;
        logic [15:0] addr;
        logic [7:0]  data;
    } exp_t;
    exp_t sb_q[$];

    logic [15:0] lat_addr = '0;
    logic [7:0]  wcap = '0;

    always #2 clk = ~clk;

    mbus_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .acc_kind(acc_kind),
        .pc(pc), .dptr(dptr), .wdata(wdata), .onchip_code_en(onchip_code_en),
        .rom_rdata(rom_rdata), .p0_in(p0_in), .p0_out(p0_out), .p0_oe(p0_oe),
        .p2_out(p2_out), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .rom_en(rom_en), .rdata(rdata), .done(done)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // external memory model: drives only while a read-type strobe is low
    assign p0_in = (!psen_n || !rd_n) ? mem_byte(lat_addr) : 8'hEE;
    always @(negedge ale) lat_addr = {p2_out, p0_out};
    always @(posedge wr_n) if (rst_n) wcap = p0_out;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // monitor: pops the scoreboard on every done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R11 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (e.kind == 2) begin
                    chk(wcap == e.data, "R8 write byte on bus", wcap, e.data);
                    chk(lat_addr == e.addr, "R12 write address latched", lat_addr, e.addr);
                end else begin
                    chk(rdata == e.data, "R6/R7/R10 returned byte", rdata, e.data);
                    if (e.ext)
                        chk(lat_addr == e.addr, "R5 latched address", lat_addr, e.addr);
                end
            end
        end
    end

    task automatic access(input int kind, input logic [15:0] a_pc,
                          input logic [15:0] a_dp, input logic [7:0] wd,
                          input bit onchip, input logic [7:0] rom);
        exp_t e;
        bit ext;
        logic [15:0] a;
        ext = !(kind == 0 && onchip && a_pc < 16'd4096);
        a = (kind == 0) ? a_pc : a_dp;
        e.kind = kind; e.ext = ext; e.addr = a;
        e.data = (kind == 2) ? wd : (!ext ? rom : mem_byte(a));
        sb_q.push_back(e);
        acc_kind = 2'(kind); pc = a_pc; dptr = a_dp; wdata = wd;
        onchip_code_en = onchip; rom_rdata = rom; acc_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        acc_start = 1'b0;
        for (int ph = 0; ph < 12; ph++) begin
            bit  e_ale, e_psen, e_rd, e_wr, e_oe;
            logic [7:0] e_p0;
            if (ph > 0) @(negedge clk);
            e_ale  = ext && ph <= 1;
            e_psen = !(ext && kind == 0 && ph >= 3 && ph <= 5);
            e_rd   = !(kind == 1 && ph >= 5 && ph <= 10);
            e_wr   = !(kind == 2 && ph >= 5 && ph <= 10);
            e_oe   = ext && (ph <= 2 || (kind == 2 && ph >= 4));
            e_p0   = (ph <= 2) ? a[7:0] : wd;
            chk(ale == e_ale, "R3 ale phase", ale, e_ale);
            chk(psen_n == e_psen, "R6 psen_n phase", psen_n, e_psen);
            chk(rd_n == e_rd, "R7 rd_n phase", rd_n, e_rd);
            chk(wr_n == e_wr, "R8 wr_n phase", wr_n, e_wr);
            chk(p0_oe == e_oe, "R9 p0_oe phase", p0_oe, e_oe);
            if (e_oe) chk(p0_out == e_p0, "R4 p0_out value", p0_out, e_p0);
            if (ext)  chk(p2_out == a[15:8], "R5 p2_out high byte", p2_out, a[15:8]);
            chk(rom_en == !ext, "R10 rom_en", rom_en, !ext);
            chk(done == (ph == 11), "R11 done timing", done, ph == 11);
        end
    endtask

    task automatic idle_check(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!ale && psen_n && rd_n && wr_n && !p0_oe && !done && !rom_en,
                "R2 idle bus quiet", {ale, psen_n, rd_n, wr_n, p0_oe, done}, 6'b011100);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!ale && psen_n && rd_n && wr_n && !p0_oe && !done && !rom_en,
            "R1 in reset", {ale, psen_n, rd_n, wr_n, p0_oe, done}, 6'b011100);
        rst_n = 1'b1;
        idle_check(2);
        // R10: pin low forces external even below the limit
        access(0, 16'h0123, 16'h0000, 8'h00, 1'b0, 8'h11);
        idle_check(2);
        // R10: on-chip fetch at the top of the on-chip range
        access(0, 16'h0FFF, 16'h0000, 8'h00, 1'b1, 8'hA7);
        idle_check(1);
        // R10: first address above the on-chip range
        access(0, 16'h1000, 16'h0000, 8'h00, 1'b1, 8'hA7);
        idle_check(1);
        // R7: external data read
        access(1, 16'h0000, 16'h8421, 8'h00, 1'b0, 8'h00);
        // R12: data read low address with on-chip code enabled
        access(1, 16'h0010, 16'h0042, 8'h00, 1'b1, 8'h00);
        idle_check(1);
        // R8: data write
        access(2, 16'h0000, 16'hBEEF, 8'h3C, 1'b1, 8'h00);
        // R11: back-to-back chain of mixed kinds
        access(0, 16'hF00D, 16'h0000, 8'h00, 1'b1, 8'h00);
        access(2, 16'h0000, 16'h0007, 8'hC5, 1'b1, 8'h00);
        access(0, 16'h0200, 16'h0000, 8'h00, 1'b1, 8'h6B);
        access(1, 16'h0000, 16'hFFFF, 8'h00, 1'b0, 8'h00);
        idle_check(3);
        chk(sb_q.size() == 0, "R11 all accesses completed", sb_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule